// File: doc/BRIEF.md
# Comparator change-detect interrupt

This block turns changes of a single asynchronous comparator result into a latched interrupt flag and a gated interrupt request. The comparator bit first passes through a flop synchronizer. An optional inversion is then applied, giving the live output. The block compares the live output against a stored reference copy. Any difference is a mismatch. A mismatch sets the flag on every cycle for as long as it lasts, so clearing the flag alone does not silence a pending change.

Software reaches four byte-wide registers over a simple single-cycle bus. A read or write of the control/status register copies the live output into the reference, which ends the mismatch. After that, a write of 0 to the flag bit clears the flag for good. Writing 1 to the flag bit raises a software interrupt. The request line is the AND of the flag, its local enable, a peripheral enable and a global enable.

Top module: `cmp_chg_irq`

## Requirements
- R1: A change of the comparator input sets the flag (bit 3 of the flag register, address 1). The flag reads 1 within four cycles of the change, with no register access in between.
- R2: While the live output differs from the reference, the flag is set again on every cycle. A later read of the flag register still shows 1.
- R3: Any read or write of the control/status register (address 0) copies the live output into the reference. A following write of 0 to the flag bit then leaves the flag at 0.
- R4: A write to address 1 loads bit 3 into the flag. 1 sets the flag and 0 clears it, provided no mismatch is active.
- R5: irq_o is 1 only when all four bits are 1: the flag, the local enable (bit 3 of address 2), the peripheral enable (bit 6 of address 3) and the global enable (bit 7 of address 3).
- R6: The flag is set by a change even when all enable bits are 0. In that case irq_o stays 0.
- R7: The control/status register reads the live output at bit 6 and the inversion control at bit 4. Its other bits read 0, and writes to them are ignored.
- R8: A control/status read in the first cycle the new synchronized value is visible returns the new value. That read captures the new value into the reference, and no flag is raised.
- R9: When a flag-clear write coincides with an active mismatch, the flag stays 1.
- R10: Changing the inversion bit flips the live output, which counts as a change and sets the flag.
- R11: After reset all flag, enable and inversion bits are 0. No flag appears after reset, even when the comparator input is 1 at reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_async_i | input | 1 | Raw comparator result, asynchronous |
| addr_i | input | 2 | Register address: 0 control/status, 1 flag, 2 enable, 3 interrupt control |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i while rd_i is 1, otherwise 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties take for granted that rd_i and wr_i are never both 1, and that each access targets exactly one register. They also assume the comparator input is steady across reset release and across the synchronizer warm-up. The stimulus drives all inputs on the falling clock edge and issues one access per cycle. It leaves at least four cycles between comparator changes, except in the coincident-read case. That case deliberately places the control/status read in the first cycle the synchronized value is visible.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR = 2'd0,
    REG_FLG = 2'd1,
    REG_ENA = 2'd2,
    REG_ICT = 2'd3
  } reg_addr_e;

  localparam int unsigned CSR_OUT_BIT  = 6;
  localparam int unsigned CSR_INV_BIT  = 4;
  localparam int unsigned FLG_BIT      = 3;
  localparam int unsigned ENA_BIT      = 3;
  localparam int unsigned ICT_PEIE_BIT = 6;
  localparam int unsigned ICT_GIE_BIT  = 7;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det #(
  parameter int unsigned WARM_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic refresh_i,
  output logic ref_o,
  output logic mismatch_o,
  output logic set_o
);
  localparam int unsigned CNT_W = $clog2(WARM_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARM_CYC);

  logic [CNT_W-1:0] warm_cnt_q;
  logic             warm;
  logic             ref_q;

  assign warm = (warm_cnt_q != CNT_END);

  // reference tracks live output until the synchronizer has filled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_cnt_q <= '0;
      ref_q      <= 1'b0;
    end else begin
      if (warm) warm_cnt_q <= warm_cnt_q + 1'b1;
      if (warm || refresh_i) ref_q <= live_i;
    end
  end

  assign ref_o      = ref_q;
  assign mismatch_o = !warm && (live_i != ref_q);
  // access in the same cycle swallows the change
  assign set_o      = mismatch_o && !refresh_i;
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              live_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              csr_acc_o,
  output logic              inv_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic inv_q, flag_q, ena_q, peie_q, gie_q;
  logic wr_csr, wr_flg, wr_ena, wr_ict;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_csr    = wr_i && (addr_i == REG_CSR);
  assign wr_flg    = wr_i && (addr_i == REG_FLG);
  assign wr_ena    = wr_i && (addr_i == REG_ENA);
  assign wr_ict    = wr_i && (addr_i == REG_ICT);
  assign csr_acc_o = (rd_i || wr_i) && (addr_i == REG_CSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q  <= 1'b0;
      flag_q <= 1'b0;
      ena_q  <= 1'b0;
      peie_q <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      if (wr_csr) inv_q <= wdata_i[CSR_INV_BIT];
      // hardware set beats software clear
      if (set_i)       flag_q <= 1'b1;
      else if (wr_flg) flag_q <= wdata_i[FLG_BIT];
      if (wr_ena) ena_q <= wdata_i[ENA_BIT];
      if (wr_ict) begin
        peie_q <= wdata_i[ICT_PEIE_BIT];
        gie_q  <= wdata_i[ICT_GIE_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        REG_CSR: begin
          rdata_o[CSR_OUT_BIT] = live_i;
          rdata_o[CSR_INV_BIT] = inv_q;
        end
        REG_FLG: rdata_o[FLG_BIT] = flag_q;
        REG_ENA: rdata_o[ENA_BIT] = ena_q;
        REG_ICT: begin
          rdata_o[ICT_PEIE_BIT] = peie_q;
          rdata_o[ICT_GIE_BIT]  = gie_q;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign inv_o  = inv_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q && ena_q && peie_q && gie_q;
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_async_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned WARM_CYC = SYNC_STAGES + 1;

  logic sync_q, inv_q, live, ref_q, mismatch, set_evt, csr_acc, flag_q;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_async_i),
    .q_o   (sync_q)
  );

  assign live = sync_q ^ inv_q;

  cmp_change_det #(.WARM_CYC(WARM_CYC)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .live_i    (live),
    .refresh_i (csr_acc),
    .ref_o     (ref_q),
    .mismatch_o(mismatch),
    .set_o     (set_evt)
  );

  cmp_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .live_i   (live),
    .set_i    (set_evt),
    .rdata_o  (rdata_o),
    .csr_acc_o(csr_acc),
    .inv_o    (inv_q),
    .flag_o   (flag_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic       irq_o,
  input logic       flag_q,
  input logic       mismatch,
  input logic       live,
  input logic       ref_q
);
  logic acc_csr, wr_flg;
  assign acc_csr = (rd_i || wr_i) && (addr_i == 2'd0);
  assign wr_flg  = wr_i && (addr_i == 2'd1);

  assert_flag_cause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(mismatch && !acc_csr) || $past(wr_flg && wdata_i[3])));

  assert_persist_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch && !acc_csr) |=> flag_q);

  assert_refresh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_csr |=> (ref_q == $past(live)));

  assert_sw_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flg && wdata_i[3]) |=> flag_q);

  assert_sw_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flg && !wdata_i[3] && !mismatch) |=> !flag_q);

  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q);

  assert_coincide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_csr && !flag_q) |=> !flag_q);

  assert_clr_loses_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_flg && mismatch) |=> flag_q);
endmodule

bind cmp_chg_irq cmp_chg_irq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .flag_q  (flag_q),
  .mismatch(mismatch),
  .live    (live),
  .ref_q   (ref_q)
);

// File: tb/sim_cmp_chg_irq.sv
module sim_cmp_chg_irq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_a = 1'b0;
  logic [1:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       probe_irq = 1'b0;
  logic       done = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_chg_irq u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmp_async_i(cmp_a),
    .addr_i     (addr),
    .rd_i       (rd),
    .wr_i       (wr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_o      (irq)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string req);
    item_t it;
    it.kind = 1; it.exp = e; it.req = req;
    exp_q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic irq_exp(input logic e, input string req);
    item_t it;
    it.kind = 2; it.exp = {7'b0, e}; it.req = req;
    exp_q.push_back(it);
    probe_irq = 1'b1;
    @(negedge clk);
    probe_irq = 1'b0;
  endtask

  // monitor: sample a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rd || probe_irq) begin
      item_t it;
      logic [7:0] act;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: unexpected sample actual=%h expected=none", rdata);
      end else begin
        it = exp_q.pop_front();
        act = (it.kind == 1) ? rdata : {7'b0, irq};
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R11 reset state
    rd_exp(2'd1, 8'h00, "R11 flag reset");
    rd_exp(2'd2, 8'h00, "R11 enable reset");
    rd_exp(2'd3, 8'h00, "R11 intctl reset");
    rd_exp(2'd0, 8'h00, "R11 csr reset");
    irq_exp(1'b0, "R11 irq reset");

    // R1 change sets flag
    cmp_a = 1'b1;
    idle(4);
    rd_exp(2'd1, 8'h08, "R1 change sets flag");
    rd_exp(2'd0, 8'h40, "R7 live output bit6");
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R3 clear after refresh");

    // R2 / R9 persistent mismatch
    cmp_a = 1'b0;
    idle(4);
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h08, "R9 clear loses to mismatch");
    idle(1);
    rd_exp(2'd1, 8'h08, "R2 mismatch persists");
    rd_exp(2'd0, 8'h00, "R3 csr read refresh");
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R3 clear sticks");

    // R4 software set / clear
    wr_reg(2'd1, 8'h08);
    rd_exp(2'd1, 8'h08, "R4 software set");
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R4 software clear");

    // R5 gating
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd2, 8'h08);
    irq_exp(1'b0, "R5 local only");
    wr_reg(2'd3, 8'h40);
    irq_exp(1'b0, "R5 no global");
    wr_reg(2'd3, 8'h80);
    irq_exp(1'b0, "R5 no peripheral");
    wr_reg(2'd3, 8'hC0);
    irq_exp(1'b1, "R5 all enabled");
    rd_exp(2'd3, 8'hC0, "R5 intctl readback");
    wr_reg(2'd2, 8'h00);
    irq_exp(1'b0, "R5 local off");
    wr_reg(2'd2, 8'h08);
    irq_exp(1'b1, "R5 local on");
    wr_reg(2'd1, 8'h00);
    irq_exp(1'b0, "R5 flag cleared");

    // R6 flag with enables off
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h00);
    cmp_a = 1'b1;
    idle(4);
    rd_exp(2'd1, 8'h08, "R6 flag with enables off");
    irq_exp(1'b0, "R6 irq held off");
    rd_exp(2'd0, 8'h40, "R7 csr high");
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R3 clear sticks again");

    // R8 read coinciding with change
    cmp_a = 1'b0;
    idle(2);
    rd_exp(2'd0, 8'h00, "R8 read sees new value");
    idle(3);
    rd_exp(2'd1, 8'h00, "R8 no flag on coincident read");

    // R10 inversion toggle
    wr_reg(2'd0, 8'h10);
    idle(2);
    rd_exp(2'd1, 8'h08, "R10 invert set counts as change");
    rd_exp(2'd0, 8'h50, "R7 invert bit4 and live");
    wr_reg(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R10 cleared");
    wr_reg(2'd0, 8'h00);
    idle(2);
    rd_exp(2'd1, 8'h08, "R10 invert clear counts as change");
    rd_exp(2'd0, 8'h00, "R7 invert off");
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'hEF);
    rd_exp(2'd0, 8'h00, "R7 unused bits ignored");
    idle(2);
    rd_exp(2'd1, 8'h00, "R7 no change from ignored bits");

    // R11 reset with input high
    rst_n = 1'b0;
    cmp_a = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    rd_exp(2'd1, 8'h00, "R11 no flag after reset");
    rd_exp(2'd0, 8'h40, "R11 live high after reset");
    rd_exp(2'd3, 8'h00, "R11 intctl after reset");
    idle(2);

    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL monitor: actual=%0d expected=0 pending items", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule